// File: doc/BRIEF.md
# Sigma-Delta Calibration Sequencer

This block is the control logic of a sigma-delta converter that runs offset and gain calibration. A host writes a two-bit mode field. A non-zero value starts a calibration sequence. The sequencer then counts output-rate ticks, steers the modulator input source and captures filtered conversion words into a zero-scale coefficient register and a full-scale coefficient register. When the measurement part of a sequence is over, the mode field reads back as zero.

The block raises an active-low data-ready flag when a calibration starts. It lowers the flag again only after one follow-on conversion of the analog input has been latched into the data register. In normal mode, every output tick latches the filtered word into the data register and lowers data-ready. A read of the data register raises the flag again.

Output-rate and modulator-cycle advance arrive as single-cycle enable pulses. The captured words are stored raw. Under bipolar coding, the shorted-input word stands for midscale, and the correction arithmetic downstream accounts for that.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, the mode readback is 00, data-ready is high (1), the source select is 00 (external pins), and the data and both coefficient registers are 0.
- R2: In normal mode, an output tick loads `filt_word` into `data_out` and drives `rdy_n` low on the next cycle. A `data_rd` pulse drives `rdy_n` high on the next cycle. If both arrive together, the load wins.
- R3: Writing mode 01 (self-calibration) selects source 01 (shorted inputs) for 3 output ticks. The word on the 3rd tick goes to `zs_coef`. The block then selects source 10 (reference over gain) for 3 ticks, and the word on the 6th tick goes to `fs_coef`. After that the source returns to 00.
- R4: During self-calibration, the mode reads 01 until the 6th tick and reads 00 after it. The word on the 9th tick goes to `data_out` and `rdy_n` goes low.
- R5: Writing mode 10 (zero-scale system step) keeps source 00. The word on the 3rd tick goes to `zs_coef`, the mode then reads 00, and `fs_coef` is unchanged. The word on the 4th tick goes to `data_out` and `rdy_n` goes low.
- R6: Writing mode 11 (full-scale system step) keeps source 00. The word on the 3rd tick goes to `fs_coef`, the mode then reads 00, and `zs_coef` is unchanged. The word on the 4th tick goes to `data_out` and `rdy_n` goes low.
- R7: If `rdy_n` is low when a calibration command is written, it stays low until the first `mod_tick` after the command and goes high on the cycle after that tick. If it is already high, it stays high.
- R8: While a calibration runs, output ticks do not change `data_out` and do not lower `rdy_n`.
- R9: A non-zero mode write during a calibration restarts from the new mode with the tick count cleared. Coefficients that the aborted sequence had not yet written keep their values.
- R10: Writing mode 00 during a calibration returns the block to normal mode at once: the mode reads 00, the source is 00, and the next tick loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 2 | Mode value written |
| orate_tick | input | 1 | Output-rate period pulse |
| mod_tick | input | 1 | Modulator-cycle pulse |
| filt_word | input | DW | Filtered conversion word |
| data_rd | input | 1 | Data register read strobe |
| mode_rd | output | 2 | Mode field readback |
| src_sel | output | 2 | Modulator input source: 00 pins, 01 shorted, 10 reference |
| rdy_n | output | 1 | Active-low data-ready |
| data_out | output | DW | Data register |
| zs_coef | output | DW | Zero-scale coefficient |
| fs_coef | output | DW | Full-scale coefficient |

## Verification
Every result is registered, so each one is due exactly one clock after the cycle in which the mode write, tick or read is presented. The late data-ready rise is due one clock after the first modulator tick that follows the command. The driver stamps each expected item with the cycle in which it falls due. The monitor compares every output only when its cycle counter reaches that stamp, sampling on the falling edge. Idle cycles between ticks confirm that nothing moves without a tick.

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int DW        = 24,
  parameter int ZS_TICKS  = 3,
  parameter int FS_TICKS  = 3,
  parameter int CONV_SELF = 3,
  parameter int CONV_SYS  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          orate_tick,
  input  logic          mod_tick,
  input  logic [DW-1:0] filt_word,
  input  logic          data_rd,
  output logic [1:0]    mode_rd,
  output logic [1:0]    src_sel,
  output logic          rdy_n,
  output logic [DW-1:0] data_out,
  output logic [DW-1:0] zs_coef,
  output logic [DW-1:0] fs_coef
);
  localparam int MAXT = (ZS_TICKS > FS_TICKS ? ZS_TICKS : FS_TICKS) > CONV_SELF ?
                        (ZS_TICKS > FS_TICKS ? ZS_TICKS : FS_TICKS) : CONV_SELF;
  localparam int CW = $clog2(MAXT + 1);

  typedef enum logic [2:0] {PH_NORM, PH_ZS_SH, PH_FS_REF, PH_ZS_EXT, PH_FS_EXT, PH_CONV} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic          self_q, pend;
  logic          zs_last, fs_last, conv_last;

  assign zs_last   = cnt == CW'(ZS_TICKS - 1);
  assign fs_last   = cnt == CW'(FS_TICKS - 1);
  assign conv_last = cnt == (self_q ? CW'(CONV_SELF - 1) : CW'(CONV_SYS - 1));
  assign mode_rd   = mode_q;
  assign src_sel   = (phase == PH_ZS_SH) ? 2'b01 : (phase == PH_FS_REF) ? 2'b10 : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_NORM; cnt <= '0; mode_q <= 2'b00; self_q <= 1'b0; pend <= 1'b0;
      rdy_n <= 1'b1; data_out <= '0; zs_coef <= '0; fs_coef <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_wdata;
      cnt    <= '0;
      self_q <= mode_wdata == 2'b01;
      pend   <= (mode_wdata != 2'b00) && !rdy_n;
      case (mode_wdata)
        2'b01:   phase <= PH_ZS_SH;
        2'b10:   phase <= PH_ZS_EXT;
        2'b11:   phase <= PH_FS_EXT;
        default: phase <= PH_NORM;
      endcase
    end else begin
      if (pend && mod_tick) begin
        rdy_n <= 1'b1; pend <= 1'b0;
      end
      if (data_rd) rdy_n <= 1'b1;
      if (orate_tick) begin
        case (phase)
          PH_NORM: begin
            data_out <= filt_word; rdy_n <= 1'b0;
          end
          PH_ZS_SH:
            if (zs_last) begin
              zs_coef <= filt_word; phase <= PH_FS_REF; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          PH_FS_REF, PH_FS_EXT:
            if (fs_last) begin
              fs_coef <= filt_word; phase <= PH_CONV; cnt <= '0; mode_q <= 2'b00;
            end else cnt <= cnt + 1'b1;
          PH_ZS_EXT:
            if (zs_last) begin
              zs_coef <= filt_word; phase <= PH_CONV; cnt <= '0; mode_q <= 2'b00;
            end else cnt <= cnt + 1'b1;
          PH_CONV:
            if (conv_last) begin
              data_out <= filt_word; rdy_n <= 1'b0; pend <= 1'b0;
              phase <= PH_NORM; cnt <= '0;
            end else cnt <= cnt + 1'b1;
          default: phase <= PH_NORM;
        endcase
      end
    end
  end

  p_fall_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> $past(orate_tick));
  p_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> ($past(mod_tick) || $past(data_rd)));
  p_high_in_cal_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_NORM && !pend) |-> rdy_n);
  p_conv_mode_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CONV) |-> (mode_q == 2'b00));
  p_fs_hold_zs_r5: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_ZS_EXT || phase == PH_ZS_SH) && !mode_wr) |=> $stable(fs_coef));
  p_data_hold_cal_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_NORM && phase != PH_CONV && !mode_wr) |=> $stable(data_out));
endmodule

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;
  localparam int DW = 24;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic mode_wr = 0, orate_tick = 0, mod_tick = 0, data_rd = 0;
  logic [1:0] mode_wdata = 0;
  logic [DW-1:0] filt_word = 0;
  logic [1:0] mode_rd, src_sel;
  logic rdy_n;
  logic [DW-1:0] data_out, zs_coef, fs_coef;

  adc_cal_seq #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .orate_tick(orate_tick), .mod_tick(mod_tick), .filt_word(filt_word),
    .data_rd(data_rd), .mode_rd(mode_rd), .src_sel(src_sel), .rdy_n(rdy_n),
    .data_out(data_out), .zs_coef(zs_coef), .fs_coef(fs_coef));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int unsigned due; string tag;
    logic [1:0] m; logic r; logic [1:0] s; logic [DW-1:0] d, z, f;
  } exp_t;
  exp_t q[$];
  exp_t e;
  int unsigned cyc = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] em = 0, esrc = 0;
  logic erdy = 1;
  logic [DW-1:0] edat = 0, ezs = 0, efs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      cmp(e.tag, "mode", DW'(mode_rd), DW'(e.m));
      cmp(e.tag, "rdy_n", DW'(rdy_n), DW'(e.r));
      cmp(e.tag, "src", DW'(src_sel), DW'(e.s));
      cmp(e.tag, "data", data_out, e.d);
      cmp(e.tag, "zs", zs_coef, e.z);
      cmp(e.tag, "fs", fs_coef, e.f);
    end
  end

  task automatic step(input logic wr, input logic [1:0] wd, input logic ot, input logic mt,
                      input logic rd, input logic [DW-1:0] w, input string tag);
    @(negedge clk);
    mode_wr = wr; mode_wdata = wd; orate_tick = ot; mod_tick = mt; data_rd = rd; filt_word = w;
    q.push_back('{cyc + 1, tag, em, erdy, esrc, edat, ezs, efs});
  endtask

  task automatic idle(input string tag);  step(0, 0, 0, 0, 0, '0, tag); endtask
  task automatic tick(input logic [DW-1:0] w, input string tag);
    step(0, 0, 1, 0, 0, w, tag); idle(tag);
  endtask
  task automatic wmode(input logic [1:0] v, input string tag); step(1, v, 0, 0, 0, '0, tag); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle("R1 reset");

    edat = 24'h111111; erdy = 0; tick(24'h111111, "R2 load");
    erdy = 1; step(0, 0, 0, 0, 1, '0, "R2 read");
    edat = 24'h222222; erdy = 0; step(0, 0, 1, 0, 1, 24'h222222, "R2 load beats read");

    // self-calibration with data-ready low at command
    em = 2'b01; esrc = 2'b01; wmode(2'b01, "R3 start");
    idle("R7 still low");
    erdy = 1; step(0, 0, 0, 1, 0, '0, "R7 rise on mod tick");
    tick(24'h000001, "R3 zs1"); tick(24'h000002, "R8 zs2");
    ezs = 24'h0A0A0A; esrc = 2'b10; tick(24'h0A0A0A, "R3 zs3");
    tick(24'h000004, "R4 fs1"); tick(24'h000005, "R4 fs2");
    efs = 24'hF0F0F0; esrc = 2'b00; em = 2'b00; tick(24'hF0F0F0, "R3 fs3 R4 mode clear");
    tick(24'h000007, "R8 conv1"); tick(24'h000008, "R8 conv2");
    edat = 24'h333333; erdy = 0; tick(24'h333333, "R4 ninth");

    // zero-scale system step
    em = 2'b10; wmode(2'b10, "R5 start");
    erdy = 1; step(0, 0, 0, 1, 0, '0, "R7 sys rise");
    tick(24'h1, "R5 t1"); tick(24'h2, "R5 t2");
    ezs = 24'h0B0B0B; em = 0; tick(24'h0B0B0B, "R5 zs");
    edat = 24'h444444; erdy = 0; tick(24'h444444, "R5 fourth");

    // full-scale system step, data-ready already high
    erdy = 1; step(0, 0, 0, 0, 1, '0, "R2 read2");
    em = 2'b11; wmode(2'b11, "R6 start");
    tick(24'h1, "R6 t1"); tick(24'h2, "R6 t2");
    efs = 24'hE0E0E0; em = 0; tick(24'hE0E0E0, "R6 fs");
    edat = 24'h555555; erdy = 0; tick(24'h555555, "R6 fourth");

    // abort and restart
    em = 2'b01; esrc = 2'b01; wmode(2'b01, "R9 start");
    erdy = 1; step(0, 0, 0, 1, 0, '0, "R7 rise again");
    tick(24'h1, "R9 a"); tick(24'h2, "R9 b");
    ezs = 24'h0C0C0C; esrc = 2'b10; tick(24'h0C0C0C, "R9 zs");
    tick(24'h4, "R9 fs1");
    em = 2'b10; esrc = 2'b00; wmode(2'b10, "R9 restart");
    tick(24'h5, "R9 r1"); tick(24'h6, "R9 r2");
    ezs = 24'h0D0D0D; em = 0; tick(24'h0D0D0D, "R9 zs keeps fs");
    edat = 24'h666666; erdy = 0; tick(24'h666666, "R9 data");

    // cancel with mode 00
    erdy = 1; step(0, 0, 0, 0, 1, '0, "R2 read3");
    em = 2'b11; wmode(2'b11, "R10 start");
    tick(24'h7, "R10 t1");
    em = 0; wmode(2'b00, "R10 cancel");
    edat = 24'h777777; erdy = 0; tick(24'h777777, "R10 normal load");
    idle("drain"); idle("drain");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule